// File: doc/BRIEF.md
# Command Queue Instruction Executor

This block is a single-thread command engine. It fetches 64-bit instructions in order from a command buffer and drives register accesses on a simple request/ready bus, where each address is a subsystem code plus a 16-bit offset. It also waits on hardware event flags, raises an interrupt at end of command and follows relative jumps. Software loads a program into the buffer, presents the first word address on `startAddr` and pulses `start`. The engine keeps `busy` high until a jump ends the program, or until an error halts it.

Each instruction word has four fields. The opcode is in bits 63:56, the subsystem code in bits 55:48, the offset or event number in bits 47:32, and the value or mask in bits 31:0. The opcodes are 0x02 (load mask), 0x04 (write), 0x08 (poll), 0x10 (jump), 0x20 (event wait/update) and 0x40 (end of command).

A mask instruction stores a bit mask. The next write or poll uses that mask only when bit 0 of its offset field is set. The engine keeps one event flag for each event number, below `NUM_EVT`. Outside logic sets or clears any flag through a per-flag set strobe and a per-flag clear strobe.

Top module: `cmdq_exec`

## Requirements
- R1: After reset, `busy`, `irq`, `err`, `busReq`, `instRd` and every event flag are 0, and the stored mask is all ones.
- R2: A write (0x04) issues one bus write. The subsystem comes from bits 55:48 and the value from bits 31:0. The bus offset is bits 47:32 with bit 0 forced to 0. The next instruction follows once `busReady` is seen.
- R3: A mask instruction (0x02) stores the inverse of its bits 31:0 as the wanted mask. A following write with offset bit 0 set reads the register first. It then writes back a value that takes the wanted-mask bits from the instruction and all other bits from the old register value.
- R4: After each masked write or masked poll completes, the stored mask returns to all ones. A later write with offset bit 0 set then writes the full value.
- R5: A poll (0x08) reads the addressed register again and again. It moves on only when the register equals bits 31:0. When offset bit 0 is set, it compares only the wanted-mask bits. No later instruction runs while it waits.
- R6: An event instruction (0x20) with bit 15 set blocks until the flag selected by bits 47:32 is 1. If bit 31 is also set, the same instruction then writes that flag: a nonzero bits 27:16 sets it and a zero clears it.
- R7: An event instruction with bit 15 clear and bit 31 set updates the flag without waiting. External `evtSet` and `evtClr` strobes change a flag on the next edge, and set wins over clear.
- R8: An event instruction whose event number is `NUM_EVT` or more sets `err`, drops `busy` and runs no further instruction.
- R9: End of command (0x40) with bit 0 set drives `irq` high for exactly one cycle. With bit 0 clear it raises no interrupt. In both cases execution continues with the next word.
- R10: A jump (0x10) adds bits 31:0, taken as a signed word offset, to its own address. A jump value of zero ends execution and drops `busy` with `err` low.
- R11: A jump placed in the last buffer slot ends execution whatever its value.
- R12: An undefined opcode sets `err` and halts execution, and the stored mask keeps its value.
- R13: `busy` is high from the edge after an accepted `start` until execution ends. A `start` while busy is ignored, and an accepted `start` clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin execution at `startAddr` when idle |
| startAddr | input | ADDR_W | First instruction word address |
| instRd | output | 1 | Instruction read strobe |
| instAddr | output | ADDR_W | Instruction word address |
| instData | input | 64 | Instruction word, valid one cycle after `instRd` |
| busReq | output | 1 | Register bus request |
| busWe | output | 1 | Register bus write enable |
| busSubsys | output | 8 | Subsystem code |
| busOffset | output | 16 | Register offset, bit 0 always 0 |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, valid with `busReady` |
| busReady | input | 1 | Access completes in this cycle |
| evtSet | input | NUM_EVT | Per-flag set strobes |
| evtClr | input | NUM_EVT | Per-flag clear strobes |
| evtFlags | output | NUM_EVT | Current event flags |
| busy | output | 1 | Engine executing |
| irq | output | 1 | One-cycle end-of-command interrupt |
| err | output | 1 | Illegal event number or undefined opcode seen |

## Verification
The assertions check the bus and interrupt rules on every cycle. They check that `irq` is never high for two cycles in a row, that the bus offset is always even and that a write always comes with a request. They also check that an idle engine makes no request, that an error always coincides with a halt, and that an external set strobe always shows up in the flags. The arithmetic of a read-modify-write, the stall of a poll or event wait, the return of the mask to all ones, the mask kept after a bad opcode, and the jump targets and end conditions can only be seen through the bench's programs and the register contents that result.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  typedef enum logic [7:0] {
    OP_MASK  = 8'h02,
    OP_WRITE = 8'h04,
    OP_POLL  = 8'h08,
    OP_JUMP  = 8'h10,
    OP_WFE   = 8'h20,
    OP_EOC   = 8'h40
  } opcode_e;

  localparam int WAIT_BIT = 15;
  localparam int UPD_BIT  = 31;
  localparam int IRQ_BIT  = 0;

  typedef struct packed {
    logic pcLoad;
    logic pcInc;
    logic pcJump;
    logic latchInst;
    logic loadMask;
    logic clrMask;
    logic latchMerge;
    logic evtUpd;
    logic raiseIrq;
    logic setErr;
    logic clrErr;
  } ctrl_strobe_t;

endpackage

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [7:0]   execOp,
  input  logic         execMasked,
  input  logic         execIrq,
  input  logic         evtIllegal,
  input  logic         jumpEnd,
  input  logic [7:0]   curOp,
  input  logic         curMasked,
  input  logic         pollHit,
  input  logic         evtHit,
  input  logic         waitBit,
  input  logic         updBit,
  input  logic         busReady,
  output ctrl_strobe_t st,
  output logic         instRd,
  output logic         busReq,
  output logic         busWe,
  output logic         busy
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EXEC, S_RD, S_WR, S_EVT} state_e;
  state_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    st     = '0;
    nxt    = state;
    instRd = 1'b0;
    busReq = 1'b0;
    busWe  = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        st.pcLoad = 1'b1;
        st.clrErr = 1'b1;
        nxt       = S_FETCH;
      end
      S_FETCH: begin
        instRd = 1'b1;
        nxt    = S_EXEC;
      end
      S_EXEC: begin
        st.latchInst = 1'b1;
        case (execOp)
          OP_MASK: begin
            st.loadMask = 1'b1;
            st.pcInc    = 1'b1;
            nxt         = S_FETCH;
          end
          OP_WRITE: nxt = execMasked ? S_RD : S_WR;
          OP_POLL:  nxt = S_RD;
          OP_WFE: begin
            if (evtIllegal) begin
              st.setErr = 1'b1;
              nxt       = S_IDLE;
            end else begin
              nxt = S_EVT;
            end
          end
          OP_EOC: begin
            st.raiseIrq = execIrq;
            st.pcInc    = 1'b1;
            nxt         = S_FETCH;
          end
          OP_JUMP: begin
            if (jumpEnd) nxt = S_IDLE;
            else begin
              st.pcJump = 1'b1;
              nxt       = S_FETCH;
            end
          end
          default: begin
            st.setErr = 1'b1;
            nxt       = S_IDLE;
          end
        endcase
      end
      S_RD: begin
        busReq = 1'b1;
        if (busReady) begin
          if (curOp == OP_POLL) begin
            if (pollHit) begin
              st.pcInc   = 1'b1;
              st.clrMask = curMasked;
              nxt        = S_FETCH;
            end
          end else begin
            st.latchMerge = 1'b1;
            nxt           = S_WR;
          end
        end
      end
      S_WR: begin
        busReq = 1'b1;
        busWe  = 1'b1;
        if (busReady) begin
          st.pcInc   = 1'b1;
          st.clrMask = curMasked;
          nxt        = S_FETCH;
        end
      end
      S_EVT: if (!waitBit || evtHit) begin
        st.evtUpd = updBit;
        st.pcInc  = 1'b1;
        nxt       = S_FETCH;
      end
      default: nxt = S_IDLE;
    endcase
  end

endmodule

// File: rtl/cmdq_dpath.sv
module cmdq_dpath
  import cmdq_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int NUM_EVT = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        st,
  input  logic [ADDR_W-1:0]   startAddr,
  input  logic [63:0]         instData,
  input  logic [31:0]         busRdata,
  input  logic [NUM_EVT-1:0]  evtSet,
  input  logic [NUM_EVT-1:0]  evtClr,
  output logic [ADDR_W-1:0]   instAddr,
  output logic [7:0]          busSubsys,
  output logic [15:0]         busOffset,
  output logic [31:0]         busWdata,
  output logic [NUM_EVT-1:0]  evtFlags,
  output logic                irq,
  output logic                err,
  output logic [7:0]          execOp,
  output logic                execMasked,
  output logic                execIrq,
  output logic                evtIllegal,
  output logic                jumpEnd,
  output logic [7:0]          curOp,
  output logic                curMasked,
  output logic                pollHit,
  output logic                evtHit,
  output logic                waitBit,
  output logic                updBit
);

  localparam int EVT_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [ADDR_W-1:0]  pc;
  logic [63:0]        instReg;
  logic [31:0]        maskReg;
  logic [31:0]        mergeReg;
  logic [NUM_EVT-1:0] flags, flagsNext;

  logic [15:0]      curOff;
  logic [31:0]      curVal;
  logic [31:0]      keepBits;
  logic [31:0]      merged;
  logic [EVT_W-1:0] evtIdx;

  assign execOp     = instData[63:56];
  assign execMasked = instData[32];
  assign execIrq    = instData[IRQ_BIT];
  assign evtIllegal = (instData[47:32] >= 16'(NUM_EVT));
  assign jumpEnd    = (instData[31:0] == 32'd0) || (pc == {ADDR_W{1'b1}});

  assign curOp     = instReg[63:56];
  assign curOff    = instReg[47:32];
  assign curVal    = instReg[31:0];
  assign curMasked = curOff[0];
  assign waitBit   = curVal[WAIT_BIT];
  assign updBit    = curVal[UPD_BIT];
  assign evtIdx    = curOff[EVT_W-1:0];
  assign evtHit    = flags[evtIdx];

  assign keepBits = curMasked ? maskReg : '1;
  assign pollHit  = (((busRdata ^ curVal) & keepBits) == 32'd0);
  assign merged   = (busRdata & ~maskReg) | (curVal & maskReg);

  assign instAddr  = pc;
  assign busSubsys = instReg[55:48];
  assign busOffset = {curOff[15:1], 1'b0};
  assign busWdata  = curMasked ? mergeReg : curVal;
  assign evtFlags  = flags;

  always_comb begin
    flagsNext = flags;
    if (st.evtUpd) flagsNext[evtIdx] = |curVal[27:16];
    flagsNext = (flagsNext & ~evtClr) | evtSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc       <= '0;
      instReg  <= '0;
      maskReg  <= '1;
      mergeReg <= '0;
      flags    <= '0;
      irq      <= 1'b0;
      err      <= 1'b0;
    end else begin
      flags <= flagsNext;
      irq   <= st.raiseIrq;
      if (st.clrErr)      err <= 1'b0;
      else if (st.setErr) err <= 1'b1;
      if (st.pcLoad)      pc <= startAddr;
      else if (st.pcJump) pc <= pc + instData[ADDR_W-1:0];
      else if (st.pcInc)  pc <= pc + 1'b1;
      if (st.latchInst)   instReg <= instData;
      if (st.loadMask)     maskReg <= ~instData[31:0];
      else if (st.clrMask) maskReg <= '1;
      if (st.latchMerge)  mergeReg <= merged;
    end
  end

endmodule

// File: rtl/cmdq_exec.sv
module cmdq_exec
  import cmdq_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int NUM_EVT = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  startAddr,
  output logic               instRd,
  output logic [ADDR_W-1:0]  instAddr,
  input  logic [63:0]        instData,
  output logic               busReq,
  output logic               busWe,
  output logic [7:0]         busSubsys,
  output logic [15:0]        busOffset,
  output logic [31:0]        busWdata,
  input  logic [31:0]        busRdata,
  input  logic               busReady,
  input  logic [NUM_EVT-1:0] evtSet,
  input  logic [NUM_EVT-1:0] evtClr,
  output logic [NUM_EVT-1:0] evtFlags,
  output logic               busy,
  output logic               irq,
  output logic               err
);

  ctrl_strobe_t st;
  logic [7:0] execOp, curOp;
  logic execMasked, execIrq, evtIllegal, jumpEnd;
  logic curMasked, pollHit, evtHit, waitBit, updBit;

  cmdq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .execOp(execOp), .execMasked(execMasked), .execIrq(execIrq),
    .evtIllegal(evtIllegal), .jumpEnd(jumpEnd),
    .curOp(curOp), .curMasked(curMasked), .pollHit(pollHit),
    .evtHit(evtHit), .waitBit(waitBit), .updBit(updBit),
    .busReady(busReady), .st(st), .instRd(instRd),
    .busReq(busReq), .busWe(busWe), .busy(busy)
  );

  cmdq_dpath #(.ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT)) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .startAddr(startAddr),
    .instData(instData), .busRdata(busRdata),
    .evtSet(evtSet), .evtClr(evtClr),
    .instAddr(instAddr), .busSubsys(busSubsys), .busOffset(busOffset),
    .busWdata(busWdata), .evtFlags(evtFlags), .irq(irq), .err(err),
    .execOp(execOp), .execMasked(execMasked), .execIrq(execIrq),
    .evtIllegal(evtIllegal), .jumpEnd(jumpEnd),
    .curOp(curOp), .curMasked(curMasked), .pollHit(pollHit),
    .evtHit(evtHit), .waitBit(waitBit), .updBit(updBit)
  );

endmodule

// File: rtl/cmdq_exec_chk.sv
module cmdq_exec_chk #(
  parameter int NUM_EVT = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               irq,
  input logic               err,
  input logic               instRd,
  input logic               busReq,
  input logic               busWe,
  input logic               busReady,
  input logic [15:0]        busOffset,
  input logic [NUM_EVT-1:0] evtSet,
  input logic [NUM_EVT-1:0] evtFlags
);

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R9

  AST_OFFSET_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !busOffset[0]); // R2

  AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> busReq); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busReq && !instRd)); // R13

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> !busy); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=> busReq); // R5

  AST_EVT_SET_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    (|evtSet) |=> ((evtFlags & $past(evtSet)) == $past(evtSet))); // R7

endmodule

bind cmdq_exec cmdq_exec_chk #(.NUM_EVT(NUM_EVT)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .irq(irq), .err(err),
  .instRd(instRd), .busReq(busReq), .busWe(busWe), .busReady(busReady),
  .busOffset(busOffset), .evtSet(evtSet), .evtFlags(evtFlags)
);

// File: tb/tb_cmdq_exec.sv
module tb_cmdq_exec;

  localparam int AW = 6;
  localparam int NE = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic instRd;
  logic [AW-1:0] instAddr;
  logic [63:0] instData = '0;
  logic busReq, busWe, busReady;
  logic [7:0] busSubsys;
  logic [15:0] busOffset;
  logic [31:0] busWdata, busRdata;
  logic [NE-1:0] evtSet = '0;
  logic [NE-1:0] evtClr = '0;
  logic [NE-1:0] evtFlags;
  logic busy, irq, err;

  logic [63:0] mem [64];
  logic [31:0] regs [16];
  logic [7:0]  lastSub = '0;
  int irqCnt = 0;
  int irqLong = 0;
  logic irqPrev = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cmdq_exec #(.ADDR_W(AW), .NUM_EVT(NE)) dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .instRd(instRd), .instAddr(instAddr), .instData(instData),
    .busReq(busReq), .busWe(busWe), .busSubsys(busSubsys),
    .busOffset(busOffset), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .evtSet(evtSet), .evtClr(evtClr),
    .evtFlags(evtFlags), .busy(busy), .irq(irq), .err(err)
  );

  assign busReady = busReq;
  assign busRdata = regs[busOffset[4:1]];

  always @(posedge clk) begin
    if (instRd) instData <= mem[instAddr];
    if (busReq && busWe) begin
      regs[busOffset[4:1]] <= busWdata;
      lastSub <= busSubsys;
    end
    if (irq) irqCnt <= irqCnt + 1;
    if (irq && irqPrev) irqLong <= irqLong + 1;
    irqPrev <= irq;
  end

  function automatic logic [63:0] mk(logic [7:0] op, logic [7:0] sb,
                                     logic [15:0] off, logic [31:0] v);
    return {op, sb, off, v};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(logic [AW-1:0] a);
    @(negedge clk);
    startAddr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(string req);
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({req, " program ends"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic tReset();
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 busReq", {31'd0, busReq}, 32'd0);
    chk("R1 flags", evtFlags, 32'd0);
  endtask

  task automatic tWrite();
    int i0 = irqCnt;
    mem[0] = mk(8'h04, 8'd3, 16'h0004, 32'hDEADBEEF);
    mem[1] = mk(8'h40, 8'd0, 16'h0000, 32'h1);
    mem[2] = mk(8'h10, 8'd0, 16'h0000, 32'h0);
    launch(0);
    chk("R13 busy after start", {31'd0, busy}, 32'd1);
    waitDone("R10");
    chk("R2 write data", regs[2], 32'hDEADBEEF);
    chk("R2 subsystem", {24'd0, lastSub}, 32'd3);
    chk("R9 irq raised once", irqCnt - i0, 32'd1);
    chk("R10 zero jump ends clean", {31'd0, err}, 32'd0);
  endtask

  task automatic tMaskWrite();
    int i0 = irqCnt;
    regs[3] = 32'h12345678;
    regs[4] = 32'hFFFFFFFF;
    mem[4] = mk(8'h02, 8'd0, 16'h0000, ~32'h0000FF00);
    mem[5] = mk(8'h04, 8'd1, 16'h0007, 32'hAABBCCDD);
    mem[6] = mk(8'h04, 8'd1, 16'h0009, 32'h11112222);
    mem[7] = mk(8'h40, 8'd0, 16'h0000, 32'h0);
    mem[8] = mk(8'h10, 8'd0, 16'h0000, 32'h0);
    launch(4);
    waitDone("R3");
    chk("R3 read-modify-write", regs[3], 32'h1234CC78);
    chk("R4 mask back to full", regs[4], 32'h11112222);
    chk("R9 no irq when bit0 clear", irqCnt - i0, 32'd0);
  endtask

  task automatic tPoll();
    regs[5] = 32'd0;
    regs[6] = 32'd0;
    regs[2] = 32'd0;
    mem[10] = mk(8'h08, 8'd0, 16'h000A, 32'd5);
    mem[11] = mk(8'h04, 8'd0, 16'h000C, 32'h0000A5A5);
    mem[12] = mk(8'h10, 8'd0, 16'h0000, 32'h0);
    launch(10);
    repeat (10) @(negedge clk);
    startAddr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 poll stalls", {31'd0, busy}, 32'd1);
    chk("R5 nothing after poll", regs[6], 32'd0);
    regs[5] = 32'd5;
    waitDone("R5");
    chk("R5 resumes on match", regs[6], 32'h0000A5A5);
    chk("R13 start while busy ignored", regs[2], 32'd0);
  endtask

  task automatic tMaskPoll();
    regs[7] = 32'h00000A05;
    regs[6] = 32'd0;
    mem[14] = mk(8'h02, 8'd0, 16'h0000, ~32'h000000F0);
    mem[15] = mk(8'h08, 8'd0, 16'h000F, 32'h00000030);
    mem[16] = mk(8'h04, 8'd0, 16'h000C, 32'h00000077);
    mem[17] = mk(8'h10, 8'd0, 16'h0000, 32'h0);
    launch(14);
    repeat (20) @(negedge clk);
    chk("R5 masked poll stalls", {31'd0, busy}, 32'd1);
    regs[7] = 32'hFFFFFF3F;
    waitDone("R5");
    chk("R5 masked compare matched", regs[6], 32'h00000077);
  endtask

  task automatic tEvents();
    mem[20] = mk(8'h20, 8'd0, 16'd5, 32'h80008001);
    mem[21] = mk(8'h20, 8'd0, 16'd7, 32'h80010000);
    mem[22] = mk(8'h20, 8'd0, 16'd9, 32'h80000000);
    mem[23] = mk(8'h10, 8'd0, 16'h0000, 32'h0);
    @(negedge clk);
    evtSet[9] = 1'b1;
    @(negedge clk);
    evtSet[9] = 1'b0;
    chk("R7 external set", {31'd0, evtFlags[9]}, 32'd1);
    launch(20);
    repeat (10) @(negedge clk);
    chk("R6 wait blocks", {31'd0, busy}, 32'd1);
    evtSet[5] = 1'b1;
    @(negedge clk);
    evtSet[5] = 1'b0;
    waitDone("R6");
    chk("R6 wait then clear", {31'd0, evtFlags[5]}, 32'd0);
    chk("R7 update sets flag", {31'd0, evtFlags[7]}, 32'd1);
    chk("R7 clear-event", {31'd0, evtFlags[9]}, 32'd0);
    evtClr[7] = 1'b1;
    @(negedge clk);
    evtClr[7] = 1'b0;
    chk("R7 external clear", {31'd0, evtFlags[7]}, 32'd0);
  endtask

  task automatic tBadEvent();
    regs[6] = 32'd0;
    mem[24] = mk(8'h20, 8'd0, 16'(NE), 32'h80008001);
    mem[25] = mk(8'h04, 8'd0, 16'h000C, 32'h00000099);
    mem[26] = mk(8'h10, 8'd0, 16'h0000, 32'h0);
    launch(24);
    waitDone("R8");
    chk("R8 err on illegal event", {31'd0, err}, 32'd1);
    chk("R8 halted before next", regs[6], 32'd0);
  endtask

  task automatic tBadOp();
    regs[7] = 32'h12345670;
    mem[28] = mk(8'h02, 8'd0, 16'h0000, ~32'h0000000F);
    mem[29] = mk(8'h55, 8'd0, 16'h0000, 32'h0);
    mem[30] = mk(8'h04, 8'd0, 16'h000F, 32'hFFFFFFFF);
    mem[31] = mk(8'h10, 8'd0, 16'h0000, 32'h0);
    mem[32] = mk(8'h10, 8'd0, 16'h0000, 32'h0);
    launch(28);
    waitDone("R12");
    chk("R12 err on bad opcode", {31'd0, err}, 32'd1);
    chk("R12 halted before next", regs[7], 32'h12345670);
    launch(30);
    waitDone("R12");
    chk("R13 start clears err", {31'd0, err}, 32'd0);
    chk("R12 mask kept", regs[7], 32'h1234567F);
  endtask

  task automatic tJump();
    regs[8] = 32'd0;
    regs[9] = 32'd0;
    regs[10] = 32'd0;
    mem[34] = mk(8'h10, 8'd0, 16'h0000, 32'd4);
    mem[35] = mk(8'h04, 8'd0, 16'h0010, 32'h00001111);
    mem[36] = mk(8'h04, 8'd0, 16'h0012, 32'h00002222);
    mem[37] = mk(8'h10, 8'd0, 16'h0000, 32'h0);
    mem[38] = mk(8'h04, 8'd0, 16'h0014, 32'h00003333);
    mem[39] = mk(8'h10, 8'd0, 16'h0000, 32'hFFFFFFFD);
    launch(34);
    waitDone("R10");
    chk("R10 forward jump skips", regs[8], 32'd0);
    chk("R10 backward jump target", regs[9], 32'h00002222);
    chk("R10 forward jump target", regs[10], 32'h00003333);
  endtask

  task automatic tLastSlot();
    regs[2] = 32'd0;
    mem[63] = mk(8'h10, 8'd0, 16'h0000, 32'd1);
    launch(63);
    waitDone("R11");
    chk("R11 no wrap to slot 0", regs[2], 32'd0);
    chk("R11 ends without err", {31'd0, err}, 32'd0);
    chk("R9 irq never two cycles", irqLong, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = mk(8'h10, 8'd0, 16'h0, 32'h0);
    for (int i = 0; i < 16; i++) regs[i] = 32'd0;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tWrite();
    tMaskWrite();
    tPoll();
    tMaskPoll();
    tEvents();
    tBadEvent();
    tBadOp();
    tJump();
    tLastSlot();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R13 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule